// File: doc/BRIEF.md
# Serial channel command and status register

This block is the host-facing register set of one channel of a multi-channel UART controller. A byte-wide host bus selects one of eight register locations per access. The block holds a pair of mode registers reached through a pointer that advances on its own. It decodes the command register into receiver and transmitter enables and a set of reset commands. It presents an eight-bit status byte, and it keeps a small receive holding FIFO that host reads drain one character at a time.

On the line side, a simple valid/ready receive port delivers characters and break events. A break enters the FIFO as a zero character. Writes to the transmit holding register leave on a one-cycle transmit strobe. Three per-channel interrupt flags (transmit ready, receive ready, break change) feed a block-level interrupt status register. A pulse output and a pulse input let two channels of a block clear each other's break-change flag.

Register locations (`reg_sel_i`): 0 mode, 1 status on read and clock select on write, 2 command (write only, reads 0), 3 receive holding on read and transmit holding on write, 4 to 7 auxiliary (writes ignored, reads 0).

Top module: `uart_chan_regs`

## Requirements
- R1: After reset the status byte is 0x00. The receiver and transmitter are disabled, the mode pointer selects the first mode register, both mode registers and the last-read character are 0x00, and every interrupt flag, `rx_ready_o`, `tx_valid_o` and `blk_brk_clr_o` are low.
- R2: A read or write at location 0 accesses the mode register chosen by the pointer, then moves the pointer to the second register. It stays there until a command with code 1 (bits 7:4) returns it to the first.
- R3: Command bit 0 enables the receiver and bit 1 disables it, and disable wins when both are set. `rx_ready_o` is high exactly when the receiver is enabled and the FIFO holds fewer than RXQ_DEPTH characters. A beat offered while it is low is discarded.
- R4: Command bit 2 sets TxRDY (status bit 2), TxEMT (status bit 3) and `irq_txrdy_o`. Command bit 3, or command code 3, clears all three, and clearing wins over setting.
- R5: Command code 2 disables the receiver, empties the FIFO and clears RxRDY (status bit 0) and `irq_rxrdy_o`. A character arriving in the same cycle is dropped.
- R6: RxRDY (status bit 0) and `irq_rxrdy_o` are high whenever the FIFO holds a character, so the first character into an empty FIFO raises them. Status bit 1 is high while the FIFO holds RXQ_DEPTH characters.
- R7: A read at location 3 returns the oldest character and removes it, so characters leave in arrival order. RxRDY falls when the last one is removed.
- R8: A read at location 3 with the FIFO empty returns the character most recently removed (0x00 if none since reset) and changes no state.
- R9: An accepted beat with `rx_brk_i` high stores 0x00 in place of `rx_data_i` and sets the break status bit (status bit 7).
- R10: A read that removes a character while status bit 7 is set clears bit 7 and raises `irq_brk_o`.
- R11: Command code 4 clears status bits 7 to 4. Command code 5 clears `irq_brk_o` and drives `blk_brk_clr_o` high during that write cycle. A high `blk_brk_clr_i` also clears `irq_brk_o`, and a same-cycle raise from R10 wins.
- R12: A write at location 3 while TxRDY is set produces `tx_valid_o` high for the next cycle, with the written byte on `tx_data_o`. A write while TxRDY is clear produces no strobe.
- R13: Writes at locations 1 and 4 to 7, and command codes 6 to 15, change no state. Reads at locations 2 and 4 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe (never together with rd_en_i) |
| rd_en_i | input | 1 | Host read strobe |
| reg_sel_i | input | 3 | Register location |
| wdata_i | input | DW | Host write data |
| rdata_o | output | DW | Read data for the selected location, valid while rd_en_i is high |
| rx_valid_i | input | 1 | Receive beat offered |
| rx_data_i | input | DW | Received character |
| rx_brk_i | input | 1 | Beat is a break event |
| rx_ready_o | output | 1 | Receive beat can be accepted |
| tx_valid_o | output | 1 | Transmit strobe |
| tx_data_o | output | DW | Transmit character |
| irq_txrdy_o | output | 1 | Transmit ready interrupt flag |
| irq_rxrdy_o | output | 1 | Receive ready interrupt flag |
| irq_brk_o | output | 1 | Break change interrupt flag |
| blk_brk_clr_o | output | 1 | Break-flag clear pulse to the sibling channel |
| blk_brk_clr_i | input | 1 | Break-flag clear pulse from the sibling channel |

## Verification
The bench builds the block with DW = 8 and RXQ_DEPTH = 3. With only three entries, the full flag, the drop of a fourth beat and pointer wrap-around are each a few beats away, so short directed runs and a random phase wrap the FIFO many times. The random phase mixes receive beats, including breaks, with reads and commands. This reaches the same-cycle cases: a pop with a push, a break raise with a neighbour clear, and an Rx reset with an arriving character.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_STAT = 3'd1,
    SEL_CMD  = 3'd2,
    SEL_DATA = 3'd3,
    SEL_AUX0 = 3'd4,
    SEL_AUX1 = 3'd5,
    SEL_AUX2 = 3'd6,
    SEL_AUX3 = 3'd7
  } reg_sel_e;

  localparam int unsigned ST_RXRDY = 0;
  localparam int unsigned ST_FULL  = 1;
  localparam int unsigned ST_TXRDY = 2;
  localparam int unsigned ST_TXEMT = 3;
  localparam int unsigned ST_BRK   = 7;

  localparam logic [3:0] OP_PTR_RST = 4'd1;
  localparam logic [3:0] OP_RX_RST  = 4'd2;
  localparam logic [3:0] OP_TX_RST  = 4'd3;
  localparam logic [3:0] OP_ERR_RST = 4'd4;
  localparam logic [3:0] OP_BRK_CLR = 4'd5;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic brk_clr;
  } cmd_act_t;

endpackage

// File: rtl/uart_chan_cmd_dec.sv
module uart_chan_cmd_dec
  import uart_chan_pkg::*;
(
  input  logic       wr_i,
  input  logic [7:0] cmd_i,
  output cmd_act_t   act_o
);

  logic [3:0] code;
  assign code = cmd_i[7:4];

  always_comb begin
    act_o         = '0;
    act_o.rx_on   = wr_i & cmd_i[0];
    act_o.rx_off  = wr_i & cmd_i[1];
    act_o.tx_on   = wr_i & cmd_i[2];
    act_o.tx_off  = wr_i & cmd_i[3];
    act_o.ptr_rst = wr_i & (code == OP_PTR_RST);
    act_o.rx_rst  = wr_i & (code == OP_RX_RST);
    act_o.tx_rst  = wr_i & (code == OP_TX_RST);
    act_o.err_rst = wr_i & (code == OP_ERR_RST);
    act_o.brk_clr = wr_i & (code == OP_BRK_CLR);
  end

endmodule

// File: rtl/uart_chan_mode.sv
module uart_chan_mode #(
  parameter int unsigned DW     = 8,
  parameter int unsigned NUM_MR = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ptr_rst_i,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned PW = (NUM_MR > 1) ? $clog2(NUM_MR) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(NUM_MR - 1);

  logic [DW-1:0] mr_q [NUM_MR];
  logic [PW-1:0] ptr_q;

  assign rdata_o = mr_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < NUM_MR; i++) mr_q[i] <= '0;
    end else if (ptr_rst_i) begin
      ptr_q <= '0;
    end else if (acc_i) begin
      if (wr_i) mr_q[ptr_q] <= wdata_i;
      if (ptr_q != PTR_LAST) ptr_q <= ptr_q + 1'b1;
    end
  end

  a_r2_ptr_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_i |=> (ptr_q == '0));
  a_r2_ptr_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !ptr_rst_i) |=> (ptr_q != '0));

endmodule

// File: rtl/uart_chan_rxq.sv
module uart_chan_rxq #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] last_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  // empty read repeats the last character handed out
  assign head_o  = empty_o ? last_q : mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      end
      if (pop_i) begin
        last_q <= mem_q[rd_q];
        rd_q   <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      end
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r7_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && cnt_q == CW'(1)) |=> empty_o);
  a_r5_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_chan_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned RXQ_DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_brk_i,
  output logic          rx_ready_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_txrdy_o,
  output logic          irq_rxrdy_o,
  output logic          irq_brk_o,
  output logic          blk_brk_clr_o,
  input  logic          blk_brk_clr_i
);

  cmd_act_t      act;
  logic          rx_en_q, txrdy_q, brk_q, irq_brk_q, tx_valid_q;
  logic [DW-1:0] tx_data_q;
  logic          q_empty, q_full, push, pop, mode_acc, tx_fire;
  logic [DW-1:0] q_head, mode_rd, push_data;
  logic [7:0]    stat;

  uart_chan_cmd_dec u_dec (
    .wr_i  (wr_en_i && reg_sel_i == SEL_CMD),
    .cmd_i (wdata_i[7:0]),
    .act_o (act)
  );

  assign mode_acc = (wr_en_i || rd_en_i) && reg_sel_i == SEL_MODE;

  uart_chan_mode #(.DW(DW), .NUM_MR(2)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (mode_acc),
    .wr_i      (wr_en_i),
    .wdata_i   (wdata_i),
    .ptr_rst_i (act.ptr_rst),
    .rdata_o   (mode_rd)
  );

  assign rx_ready_o = rx_en_q && !q_full;
  assign push       = rx_valid_i && rx_ready_o && !act.rx_rst;
  assign push_data  = rx_brk_i ? '0 : rx_data_i;
  assign pop        = rd_en_i && reg_sel_i == SEL_DATA && !q_empty;
  assign tx_fire    = wr_en_i && reg_sel_i == SEL_DATA && txrdy_q;

  uart_chan_rxq #(.DW(DW), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .flush_i     (act.rx_rst),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .full_o      (q_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q    <= 1'b0;
      txrdy_q    <= 1'b0;
      brk_q      <= 1'b0;
      irq_brk_q  <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      // disable and reset commands override enables
      if (act.rx_off || act.rx_rst) rx_en_q <= 1'b0;
      else if (act.rx_on)           rx_en_q <= 1'b1;
      if (act.tx_off || act.tx_rst) txrdy_q <= 1'b0;
      else if (act.tx_on)           txrdy_q <= 1'b1;
      brk_q      <= (brk_q && !act.err_rst && !pop) || (push && rx_brk_i);
      irq_brk_q  <= (irq_brk_q && !act.brk_clr && !blk_brk_clr_i) || (pop && brk_q);
      tx_valid_q <= tx_fire;
      if (tx_fire) tx_data_q <= wdata_i;
    end
  end

  always_comb begin
    stat           = '0;
    stat[ST_RXRDY] = !q_empty;
    stat[ST_FULL]  = q_full;
    stat[ST_TXRDY] = txrdy_q;
    stat[ST_TXEMT] = txrdy_q;
    stat[ST_BRK]   = brk_q;
  end

  always_comb begin
    unique case (reg_sel_i)
      SEL_MODE: rdata_o = mode_rd;
      SEL_STAT: rdata_o = DW'(stat);
      SEL_DATA: rdata_o = q_head;
      default:  rdata_o = '0;
    endcase
  end

  assign tx_valid_o    = tx_valid_q;
  assign tx_data_o     = tx_data_q;
  assign irq_txrdy_o   = txrdy_q;
  assign irq_rxrdy_o   = !q_empty;
  assign irq_brk_o     = irq_brk_q;
  assign blk_brk_clr_o = act.brk_clr;

  a_r3_rx_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.rx_off || act.rx_rst) |=> !rx_ready_o);
  a_r4_tx_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.tx_on && !act.tx_off && !act.tx_rst) |=> irq_txrdy_o);
  a_r4_tx_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.tx_off || act.tx_rst) |=> !irq_txrdy_o);
  a_r6_rxrdy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !irq_rxrdy_o) |=> irq_rxrdy_o);
  a_r10_brk_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && brk_q) |=> irq_brk_o);
  a_r11_nbr_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_brk_clr_i && !(pop && brk_q)) |=> !irq_brk_o);
  a_r12_tx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == SEL_DATA && !txrdy_q) |=> !tx_valid_o);
  a_r12_tx_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fire |=> (tx_valid_o && tx_data_o == $past(wdata_i)));

endmodule

// File: tb/sim_uart_chan_regs.sv
module sim_uart_chan_regs;

  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] wd = '0, rdata;
  logic       rx_v = 1'b0, rx_b = 1'b0, rx_rdy;
  logic [7:0] rx_d = '0;
  logic       tx_v;
  logic [7:0] tx_d;
  logic       i_tx, i_rx, i_brk, clr_o, clr_i = 1'b0;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  uart_chan_regs #(.DW(8), .RXQ_DEPTH(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .reg_sel_i(sel), .wdata_i(wd), .rdata_o(rdata),
    .rx_valid_i(rx_v), .rx_data_i(rx_d), .rx_brk_i(rx_b), .rx_ready_o(rx_rdy),
    .tx_valid_o(tx_v), .tx_data_o(tx_d),
    .irq_txrdy_o(i_tx), .irq_rxrdy_o(i_rx), .irq_brk_o(i_brk),
    .blk_brk_clr_o(clr_o), .blk_brk_clr_i(clr_i)
  );

  // behavioural reference
  byte unsigned q[$];
  bit        m_rx_en, m_tx, m_brk, m_ibrk, m_ptr, m_txv;
  logic [7:0] m_mr[2];
  logic [7:0] m_last, m_txd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_rx_en = 0; m_tx = 0; m_brk = 0; m_ibrk = 0; m_ptr = 0; m_txv = 0;
      m_mr[0] = 0; m_mr[1] = 0; m_last = 0; m_txd = 0;
    end else begin
      bit ready0, brk0, tx0, rx_reset;
      ready0 = m_rx_en && q.size() < 3;
      brk0 = m_brk; tx0 = m_tx; rx_reset = 0;
      if (wr_en && sel == 3'd2) begin
        if (wd[0]) m_rx_en = 1;
        if (wd[1]) m_rx_en = 0;
        if (wd[2]) m_tx = 1;
        if (wd[3]) m_tx = 0;
        case (wd[7:4])
          4'd1: m_ptr = 0;
          4'd2: begin m_rx_en = 0; q.delete(); rx_reset = 1; end
          4'd3: m_tx = 0;
          4'd4: m_brk = 0;
          4'd5: m_ibrk = 0;
          default: ;
        endcase
      end
      if (clr_i) m_ibrk = 0;
      m_txv = wr_en && sel == 3'd3 && tx0;
      if (m_txv) m_txd = wd;
      if ((wr_en || rd_en) && sel == 3'd0) begin
        if (wr_en) m_mr[m_ptr] = wd;
        m_ptr = 1;
      end
      if (rd_en && sel == 3'd3 && q.size() > 0) begin
        m_last = q.pop_front();
        if (brk0) begin m_brk = 0; m_ibrk = 1; end
      end
      if (rx_v && ready0 && !rx_reset) begin
        q.push_back(rx_b ? 8'h00 : rx_d);
        if (rx_b) m_brk = 1;
      end
    end
  end

  function automatic logic [7:0] m_stat();
    return {m_brk, 3'b000, m_tx, m_tx, q.size() == 3, q.size() != 0};
  endfunction

  function automatic logic [7:0] m_rdata();
    case (sel)
      3'd0: return m_mr[m_ptr];
      3'd1: return m_stat();
      3'd3: return (q.size() > 0) ? q[0] : m_last;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #3;
      chk("R3 rx_ready", rx_rdy, m_rx_en && q.size() < 3);
      chk("R4 irq_txrdy", i_tx, m_tx);
      chk("R6 irq_rxrdy", i_rx, q.size() != 0);
      chk("R10 irq_brk", i_brk, m_ibrk);
      chk("R12 tx_valid", tx_v, m_txv);
      if (m_txv) chk("R12 tx_data", tx_d, m_txd);
      chk("R11 clr_out", clr_o, wr_en && sel == 3'd2 && wd[7:4] == 4'd5);
      if (rd_en) begin
        case (sel)
          3'd0: chk("R2 mode read", rdata, m_rdata());
          3'd1: chk("R9 status read", rdata, m_rdata());
          3'd3: chk("R7 data read", rdata, m_rdata());
          default: chk("R13 aux read", rdata, m_rdata());
        endcase
      end
    end
  end

  task automatic drive(input bit w, input bit r, input logic [2:0] s, input logic [7:0] d,
                       input bit v, input logic [7:0] rd, input bit b, input bit c);
    @(negedge clk);
    wr_en = w; rd_en = r; sel = s; wd = d; rx_v = v; rx_d = rd; rx_b = b; clr_i = c;
  endtask

  task automatic idle();         drive(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [2:0] s, input logic [7:0] d); drive(1, 0, s, d, 0, 0, 0, 0); endtask
  task automatic rx(input logic [7:0] d); drive(0, 0, 0, 0, 1, d, 0, 0); endtask
  task automatic rx_break();     drive(0, 0, 0, 0, 1, 8'hA5, 1, 0); endtask

  task automatic rd_chk(input logic [2:0] s, input logic [7:0] e, input string tag);
    drive(0, 1, s, 0, 0, 0, 0, 0);
    #4;
    chk(tag, rdata, e);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(3'd1, 8'h00, "R1 status after reset");
    chk("R1 irq flags", {i_tx, i_rx, i_brk, rx_rdy, tx_v}, 0);
    rd_chk(3'd3, 8'h00, "R1 last char");
    // R2 mode pointer
    rd_chk(3'd0, 8'h00, "R2 first mode reg");
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h13); wr(3'd0, 8'h97);
    rd_chk(3'd0, 8'h97, "R2 pointer holds second");
    wr(3'd2, 8'h10);
    rd_chk(3'd0, 8'h13, "R2 pointer reset");
    rd_chk(3'd0, 8'h97, "R2 pointer advanced");
    // R4 / R12 transmitter
    wr(3'd2, 8'h04);
    rd_chk(3'd1, 8'h0C, "R4 tx enable");
    wr(3'd3, 8'h5A); idle(); #4; chk("R12 tx strobe", {tx_v, tx_d}, {1'b1, 8'h5A});
    wr(3'd2, 8'h08);
    rd_chk(3'd1, 8'h00, "R4 tx disable");
    wr(3'd3, 8'h66); idle(); #4; chk("R12 dropped write", tx_v, 0);
    wr(3'd2, 8'h0C);
    rd_chk(3'd1, 8'h00, "R4 disable wins");
    wr(3'd2, 8'h04); wr(3'd2, 8'h30);
    rd_chk(3'd1, 8'h00, "R4 tx reset");
    wr(3'd2, 8'h04);
    // R3 / R6 / R7 / R8 receive path
    wr(3'd2, 8'h01);
    rx(8'hA1); rx(8'hB2); rx(8'hC3); idle();
    rd_chk(3'd1, 8'h0F, "R6 full status");
    chk("R3 ready low when full", rx_rdy, 0);
    rx(8'hD4);
    rd_chk(3'd3, 8'hA1, "R7 order 1");
    rd_chk(3'd3, 8'hB2, "R7 order 2");
    rd_chk(3'd3, 8'hC3, "R7 order 3");
    rd_chk(3'd1, 8'h0C, "R7 empty after drain");
    rd_chk(3'd3, 8'hC3, "R8 empty read");
    rd_chk(3'd3, 8'hC3, "R8 empty read again");
    rd_chk(3'd1, 8'h0C, "R8 no state change");
    // R9 / R10 break
    rx_break();
    rd_chk(3'd1, 8'h8D, "R9 break status");
    rx(8'h44);
    rd_chk(3'd3, 8'h00, "R9 zero char");
    idle(); #4; chk("R10 irq_brk raised", i_brk, 1);
    rd_chk(3'd1, 8'h0D, "R10 break bit cleared");
    rd_chk(3'd3, 8'h44, "R7 after break");
    // R11 clears
    wr(3'd2, 8'h50); idle(); #4; chk("R11 code 5 clear", i_brk, 0);
    rx_break(); wr(3'd2, 8'h40);
    rd_chk(3'd1, 8'h0D, "R11 error reset");
    rd_chk(3'd3, 8'h00, "R11 zero char read");
    idle(); #4; chk("R11 no irq after err reset", i_brk, 0);
    rx_break();
    rd_chk(3'd3, 8'h00, "R9 break char");
    drive(0, 0, 0, 0, 0, 0, 0, 1); idle(); #4; chk("R11 neighbour clear", i_brk, 0);
    // R5 rx reset
    rx(8'h11); rx(8'h22); wr(3'd2, 8'h20);
    rd_chk(3'd1, 8'h0C, "R5 fifo emptied");
    chk("R5 receiver off", rx_rdy, 0);
    rd_chk(3'd3, 8'h00, "R8 last after rx reset");
    rx(8'h33);
    rd_chk(3'd1, 8'h0C, "R3 beat ignored when off");
    wr(3'd2, 8'h01); wr(3'd2, 8'h03); rx(8'h33);
    rd_chk(3'd1, 8'h0C, "R3 disable wins");
    // R13 ignored accesses
    wr(3'd2, 8'h01); rx(8'h77);
    wr(3'd1, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    wr(3'd2, 8'h60); wr(3'd2, 8'hF0); wr(3'd2, 8'h70);
    rd_chk(3'd1, 8'h0D, "R13 status unchanged");
    rd_chk(3'd0, 8'h97, "R13 mode unchanged");
    rd_chk(3'd4, 8'h00, "R13 aux read");
    rd_chk(3'd2, 8'h00, "R13 command read");
    // same-cycle push and pop
    drive(0, 1, 3'd3, 0, 1, 8'h88, 0, 0); #4; chk("R7 head with push", rdata, 8'h77);
    rd_chk(3'd3, 8'h88, "R7 pushed during pop");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned k;
      bit w, r;
      k = $urandom_range(0, 9);
      w = (k < 3); r = (k >= 3 && k < 7);
      drive(w, r, 3'($urandom_range(0, 7)),
            (k == 0) ? 8'($urandom_range(0, 5) << 4 | $urandom_range(0, 15)) : 8'($urandom),
            $urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 5) == 0,
            $urandom_range(0, 15) == 0);
    end
    idle(); idle();
    finish_run();
  end

endmodule